// File: doc/BRIEF.md
# Mirrored Four-Read-Port RAM

This block offers a memory with four independent read ports and one write port. It is built from four identical synchronous RAM copies placed side by side. Every write goes into all four copies on the same clock edge, so the copies always hold the same contents. Each read port then reads from its own copy, and up to four reads are served in parallel.

A parameter picks the kind of copy. A one-port copy has a single address shared by its read and its write, so it can do either a read or a write in a cycle. A two-port copy has a separate read port and write port. In one-port mode a write takes priority over reads in the same cycle: the write is performed and every read requested in that cycle is refused with a per-port stall. In two-port mode a write and all four reads are accepted together. A read of the address being written in that cycle returns the old word.

Read data and a per-port valid flag appear one cycle after an accepted request. The data output of a port keeps its last value until that port completes another read.

Top module: `quad_read_ram`

## Requirements
- R1: A write (`wr_en` high) stores `wr_data` at `wr_addr` in all four copies on the same clock edge, so a later read of that address returns the same word on every read port.
- R2: A read accepted at a clock edge (`rd_en[i]` high and `rd_stall[i]` low) drives `rd_valid[i]` high and `rd_data` slice i with the stored word after that edge, one cycle later. `rd_valid[i]` is low after an edge where port i had no accepted read.
- R3: Read port i uses `rd_addr[i*ADDR_W +: ADDR_W]` and `rd_data[i*DATA_W +: DATA_W]`. The four ports read independent addresses in the same cycle.
- R4: With `MODE = COPY_ONE_PORT`, a cycle with `wr_en` high drives `rd_stall` equal to `rd_en` in that same cycle. The write is performed, the stalled ports give no `rd_valid` next cycle, and their data does not change.
- R5: With `MODE = COPY_TWO_PORT`, `rd_stall` is always zero, and a write and four reads in one cycle are all performed.
- R6: With `MODE = COPY_TWO_PORT`, a read of the address written in the same cycle returns the word held before that write.
- R7: A port's `rd_data` slice keeps its value across cycles where that port has no accepted read.
- R8: While `rst_n` is low at a clock edge, `rd_valid` and `rd_data` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all requests are captured on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | NUM_RD | Per-port read request |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses, port i at bits i*ADDR_W |
| rd_stall | output | NUM_RD | Same-cycle rejection of a port's read request |
| rd_valid | output | NUM_RD | Read data valid, one cycle after acceptance |
| rd_data | output | NUM_RD*DATA_W | Read data, port i at bits i*DATA_W |

## Verification
The assertions check the per-cycle handshake on every cycle. In one-port mode a stall matches exactly the ports requesting while a write is present. In two-port mode no stall is ever raised. Valid follows the accepted reads by one cycle, and a port's data stays put when it had no accepted read. The contents can only be shown by the bench's scenarios: mirroring across copies, independent addressing, write priority and the old-data return on a same-address read in two-port mode. The bench sweeps every address on every port, every read mask against a write, and pseudo-random traffic, and it models both modes against one reference array.

// File: rtl/qrr_pkg.sv
// Package: shared types for the mirrored four-read-port RAM.
// Assumes nothing beyond IEEE 1800-2017 enums.
package qrr_pkg;

    // Kind of each replicated RAM copy.
    typedef enum logic {
        COPY_ONE_PORT = 1'b0,   // one shared address: read or write per cycle
        COPY_TWO_PORT = 1'b1    // separate read and write ports
    } copy_kind_e;

endpackage

// File: rtl/qrr_port_guard.sv
// Module: qrr_port_guard
// Decides which read requests a cycle can accept. A write is always
// accepted. In one-port mode a write occupies every copy, so all reads
// of that cycle are refused; in two-port mode every read is accepted.
// Assumes the stall is used combinationally in the request cycle.
module qrr_port_guard
    import qrr_pkg::*;
#(
    parameter int         NUM_RD = 4,
    parameter copy_kind_e MODE   = COPY_ONE_PORT
) (
    input  logic              wr_en,
    input  logic [NUM_RD-1:0] rd_en,
    output logic [NUM_RD-1:0] rd_grant,
    output logic [NUM_RD-1:0] rd_stall
);

    logic write_blocks;

    // Purpose: a write blocks reads only when copies have one port.
    always_comb begin
        write_blocks = (MODE == COPY_ONE_PORT) && wr_en;
        rd_stall     = rd_en & {NUM_RD{write_blocks}};
        rd_grant     = rd_en & ~rd_stall;
    end

endmodule

// File: rtl/qrr_copy.sv
// Module: qrr_copy
// One behavioural synchronous RAM copy. Address, data and enables are
// captured on the rising clock edge; read data is registered and holds
// its value between reads. MODE picks a one-port or two-port copy.
// Assumes the caller never grants a read together with a write in
// one-port mode (the copy still gives the write priority).
module qrr_copy
    import qrr_pkg::*;
#(
    parameter int         ADDR_W = 4,
    parameter int         DATA_W = 8,
    parameter copy_kind_e MODE   = COPY_ONE_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        if (MODE == COPY_ONE_PORT) begin : g_one_port
            logic [ADDR_W-1:0] port_addr;

            // Purpose: the single port takes the write address when writing.
            always_comb port_addr = wr_en ? wr_addr : rd_addr;

            // Purpose: store the word through the shared port.
            always_ff @(posedge clk) begin
                if (wr_en) begin
                    mem[port_addr] <= wr_data;
                end
            end

            // Purpose: register read data; a write takes the port instead.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rd_data <= '0;
                end else if (rd_en && !wr_en) begin
                    rd_data <= mem[port_addr];
                end
            end
        end else begin : g_two_port
            // Purpose: store the word through the dedicated write port.
            always_ff @(posedge clk) begin
                if (wr_en) begin
                    mem[wr_addr] <= wr_data;
                end
            end

            // Purpose: register read data; same-edge write is not yet visible.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rd_data <= '0;
                end else if (rd_en) begin
                    rd_data <= mem[rd_addr];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/quad_read_ram.sv
// Module: quad_read_ram
// Multi-read-port memory built from NUM_RD mirrored RAM copies. Every
// write is broadcast to all copies on one edge; read port i is served
// by copy i. The port guard refuses reads that collide with a write
// in one-port mode. Data and valid appear one cycle after acceptance.
// Assumes one clock domain and that memory contents start undefined.
module quad_read_ram
    import qrr_pkg::*;
#(
    parameter int         ADDR_W = 4,
    parameter int         DATA_W = 8,
    parameter int         NUM_RD = 4,
    parameter copy_kind_e MODE   = COPY_ONE_PORT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NUM_RD-1:0]        rd_en,
    input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
    output logic [NUM_RD-1:0]        rd_stall,
    output logic [NUM_RD-1:0]        rd_valid,
    output logic [NUM_RD*DATA_W-1:0] rd_data
);

    logic [NUM_RD-1:0] rd_grant;

    qrr_port_guard #(
        .NUM_RD (NUM_RD),
        .MODE   (MODE)
    ) u_guard (
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rd_grant (rd_grant),
        .rd_stall (rd_stall)
    );

    generate
        for (genvar g = 0; g < NUM_RD; g++) begin : g_copy
            qrr_copy #(
                .ADDR_W (ADDR_W),
                .DATA_W (DATA_W),
                .MODE   (MODE)
            ) u_copy (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .rd_en   (rd_grant[g]),
                .rd_addr (rd_addr[g*ADDR_W +: ADDR_W]),
                .rd_data (rd_data[g*DATA_W +: DATA_W])
            );
        end
    endgenerate

    // Purpose: flag each port whose read was accepted on the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= '0;
        end else begin
            rd_valid <= rd_grant;
        end
    end

endmodule

// File: rtl/qrr_checker.sv
// Module: qrr_checker
// Per-cycle protocol properties of quad_read_ram, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled
// while rst_n is low.
module qrr_checker
    import qrr_pkg::*;
#(
    parameter int         DATA_W = 8,
    parameter int         NUM_RD = 4,
    parameter copy_kind_e MODE   = COPY_ONE_PORT
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [NUM_RD-1:0]        rd_en,
    input logic [NUM_RD-1:0]        rd_stall,
    input logic [NUM_RD-1:0]        rd_valid,
    input logic [NUM_RD*DATA_W-1:0] rd_data
);

    generate
        if (MODE == COPY_ONE_PORT) begin : g_one
            AST_WRITE_STALLS_READS: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |-> (rd_stall == rd_en)); // R4
            AST_NO_STALL_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |-> (rd_stall == '0)); // R4
        end else begin : g_two
            AST_NEVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
                rd_stall == '0); // R5
        end
    endgenerate

    AST_VALID_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_valid == $past(rd_en & ~rd_stall))); // R2

    generate
        for (genvar i = 0; i < NUM_RD; i++) begin : g_hold
            AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !(rd_en[i] && !rd_stall[i]) |=> $stable(rd_data[i*DATA_W +: DATA_W])); // R7
        end
    endgenerate

endmodule

bind quad_read_ram qrr_checker #(
    .DATA_W (DATA_W),
    .NUM_RD (NUM_RD),
    .MODE   (MODE)
) u_qrr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_stall (rd_stall),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/quad_read_ram_bench.sv
// Bench: drives both copy kinds with identical stimulus and compares
// every port against one reference array and a per-mode output model.
module quad_read_ram_bench;
    import qrr_pkg::*;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NR = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NR-1:0] rd_en = '0;
    logic [NR*AW-1:0] rd_addr = '0;

    logic [NR-1:0] stall_s, valid_s, stall_d, valid_d;
    logic [NR*DW-1:0] data_s, data_d;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] exp_s [NR];
    logic [DW-1:0] exp_d [NR];
    logic [NR-1:0] expv_s, expv_d;

    always #5 clk = ~clk;

    quad_read_ram #(.ADDR_W(AW), .DATA_W(DW), .NUM_RD(NR), .MODE(COPY_ONE_PORT)) u_quad_read_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_stall(stall_s), .rd_valid(valid_s), .rd_data(data_s)
    );

    quad_read_ram #(.ADDR_W(AW), .DATA_W(DW), .NUM_RD(NR), .MODE(COPY_TWO_PORT)) u_quad_read_ram_two (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_stall(stall_d), .rd_valid(valid_d), .rd_data(data_d)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One request cycle, driven just after a falling edge; outputs checked
    // at the next falling edge after the capturing rising edge.
    task automatic run_cycle(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                             input logic [NR-1:0] re, input logic [NR*AW-1:0] ra, input string tag);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        #1;
        chk("R4 stall one-port", 32'(stall_s), we ? 32'(re) : 32'd0);
        chk("R5 stall two-port", 32'(stall_d), 32'd0);
        for (int p = 0; p < NR; p++) begin
            if (re[p] && !we) exp_s[p] = ref_mem[ra[p*AW +: AW]];
            if (re[p]) exp_d[p] = ref_mem[ra[p*AW +: AW]];
        end
        expv_s = we ? '0 : re;
        expv_d = re;
        if (we) ref_mem[wa] = wd;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " valid one-port"}, 32'(valid_s), 32'(expv_s));
        chk({tag, " valid two-port"}, 32'(valid_d), 32'(expv_d));
        for (int p = 0; p < NR; p++) begin
            chk({tag, " data one-port"}, 32'(data_s[p*DW +: DW]), 32'(exp_s[p]));
            chk({tag, " data two-port"}, 32'(data_d[p*DW +: DW]), 32'(exp_d[p]));
        end
    endtask

    function automatic logic [NR*AW-1:0] same_addr(input logic [AW-1:0] a);
        return {NR{a}};
    endfunction

    initial begin
        logic [15:0] lfsr;
        for (int p = 0; p < NR; p++) begin exp_s[p] = '0; exp_d[p] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: outputs cleared during reset
        chk("R8 valid one-port", 32'(valid_s), 32'd0);
        chk("R8 valid two-port", 32'(valid_d), 32'd0);
        chk("R8 data one-port", 32'(data_s), 32'd0);
        chk("R8 data two-port", 32'(data_d), 32'd0);
        rst_n = 1'b1;

        // R1: fill every address, no reads
        for (int a = 0; a < DEPTH; a++)
            run_cycle(1'b1, AW'(a), DW'(a * 7 + 3), '0, '0, "R1");
        // R1: every port reads the same address; all copies must agree
        for (int a = 0; a < DEPTH; a++)
            run_cycle(1'b0, '0, '0, '1, same_addr(AW'(a)), "R1");
        // R3: four distinct addresses per cycle
        for (int a = 0; a < DEPTH; a++)
            run_cycle(1'b0, '0, '0, '1,
                      {AW'(a + 3), AW'(a + 2), AW'(a + 1), AW'(a)}, "R3");
        // R4/R5/R6: every read mask against a write to the address being read
        for (int m = 0; m < (1 << NR); m++) begin
            run_cycle(1'b1, AW'(m), DW'(8'hA0 + m), NR'(m), same_addr(AW'(m)), "R6");
            // R7: idle cycle, all data must hold
            run_cycle(1'b0, '0, '0, '0, '0, "R7");
        end
        // R1/R2: the writes above landed in every copy
        for (int a = 0; a < DEPTH; a++)
            run_cycle(1'b0, '0, '0, '1, same_addr(AW'(a)), "R2");
        // R3: pseudo-random mix of reads and writes
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_cycle(lfsr[0] & lfsr[5], lfsr[4:1], lfsr[15:8], lfsr[9:6],
                      {lfsr[3:0], lfsr[7:4], lfsr[11:8], lfsr[15:12]}, "R3");
        end
        // R1: final mirror sweep
        for (int a = 0; a < DEPTH; a++)
            run_cycle(1'b0, '0, '0, '1, same_addr(AW'(a)), "R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule